// File: doc/BRIEF.md
# Error-Tagged Receive Buffer with Trigger Interrupt

This block queues received characters between a serial receiver and the host register interface. Each entry holds the character together with three error flags: framing, parity and overrun. The oldest entry is always visible. Its character is on `hold_char` and its flags are on three separate status outputs, so the host can inspect a character's errors before taking it. Only a data read removes an entry. A status read leaves the queue unchanged, so the host must read the status first and the byte second.

The block produces three flags: a data-ready flag, a trigger-level flag, and a receive interrupt request. In queue mode the interrupt fires when the fill level reaches a programmable trigger. A status read can silence it while the level stays at or above the trigger. In single-register mode the store holds one entry and data-ready alone drives the interrupt.

Top module: `rx_tagged_fifo`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `data_ready`, `trig_flag`, `rx_irq`, `hold_char` and the three head error outputs are all 0.
- R2: When the store is not empty, `hold_char`, `head_frame_err`, `head_parity_err` and `head_overrun_err` show the oldest stored entry, each flag on its own output exactly as it was written.
- R3: The oldest entry is removed only by a `rd_data` strobe. A `rd_status` strobe leaves the head outputs and the fill level unchanged.
- R4: `data_ready` is high in the cycle after a write. It falls in the cycle after the read that empties the store. A `rd_data` strobe on an empty store changes nothing.
- R5: In queue mode (`fifo_mode`=1) up to 16 entries are held and returned in write order, including across the wrap of the storage.
- R6: A write when the store is full discards the new character and sets the overrun flag of the newest stored entry. All other entries stay unchanged.
- R7: In queue mode `trig_flag` is high in the cycle after the fill level becomes at least the effective trigger, and falls in the cycle after the level drops below it. A `trig_level` of 0 acts as 1 and values above 16 act as 16. A `rd_status` strobe does not clear `trig_flag`.
- R8: With `irq_enable`=1, `rx_irq` rises in the cycle after the fill level reaches the effective trigger.
- R9: A `rd_status` strobe while the trigger condition holds drops `rx_irq` in the next cycle. `rx_irq` stays low while the level remains at or above the trigger, and re-asserts only after the level has gone below the trigger and then reached it again.
- R10: A data read that takes the level below the trigger drops `rx_irq` and `trig_flag` in the next cycle.
- R11: With `fifo_mode`=0 the store holds a single entry, so a second write is treated as an overrun (R6). `trig_flag` stays low and `rx_irq` follows `data_ready`, with status-read silencing as in R9.
- R12: With `irq_enable`=0, `rx_irq` is low. A trigger condition that nobody silenced raises `rx_irq` in the cycle after `irq_enable` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_char | input | 8 | Received character |
| wr_frame_err | input | 1 | Framing error of the written character |
| wr_parity_err | input | 1 | Parity error of the written character |
| wr_overrun_err | input | 1 | Overrun error of the written character |
| rd_data | input | 1 | Data-register read strobe; removes the head entry |
| rd_status | input | 1 | Line-status read strobe; can silence the interrupt |
| fifo_mode | input | 1 | 1: 16-entry queue, 0: single holding register |
| irq_enable | input | 1 | Receive interrupt enable |
| trig_level | input | 5 | Trigger level (0 acts as 1, above 16 acts as 16) |
| hold_char | output | 8 | Character of the head entry, 0 when empty |
| head_frame_err | output | 1 | Framing flag of the head entry |
| head_parity_err | output | 1 | Parity flag of the head entry |
| head_overrun_err | output | 1 | Overrun flag of the head entry |
| data_ready | output | 1 | Store not empty |
| trig_flag | output | 1 | Fill level at or above the trigger (queue mode only) |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A wrong read pointer or fill count shows up immediately on the head outputs. The bench compares the head against the expected entry after every read, so a skipped, doubled or misordered entry fails on the next sample. Full-store errors show up later, during the drain: a lost overrun mark or an overwritten entry appears only when that entry reaches the head. A stale silence or trigger state shows on `rx_irq` or `trig_flag` in the cycle after the write or read that crosses the trigger.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int RXQ_CHAR_W = 8;

  // Stored part of an entry; the overrun flag lives in a separate flop
  // vector because it can be set after the entry is written.
  typedef struct packed {
    logic                  frame;
    logic                  parity;
    logic [RXQ_CHAR_W-1:0] ch;
  } rxq_word_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  rxq_word_t     word_i,
  input  logic          ovr_i,
  input  logic          pop_i,
  input  logic          single_i,
  output rxq_word_t     head_o,
  output logic          head_ovr_o,
  output logic [CW-1:0] cnt_nxt_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  rxq_word_t         mem [DEPTH];
  logic [DEPTH-1:0]  ovr_q;
  logic [AW-1:0]     rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]     cnt_q, cnt_nxt, cap;
  logic              empty, full, pop_ok, push_ok, ovr_hit;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_C) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? LAST_C : p - AW'(1);
  endfunction

  assign cap     = single_i ? CW'(1) : DEPTH_C;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q >= cap);
  assign pop_ok  = pop_i && !empty;
  assign push_ok = push_i && (!full || pop_ok);
  assign ovr_hit = push_i && !push_ok;

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_ok && !pop_ok)      cnt_nxt = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_nxt = cnt_q - CW'(1);
  end

  // Payload array: no reset, single write port, for RAM inference.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= word_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q    <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) begin
        ovr_q[wr_ptr_q] <= ovr_i;
        wr_ptr_q        <= ptr_inc(wr_ptr_q);
      end
      if (ovr_hit) ovr_q[ptr_dec(wr_ptr_q)] <= 1'b1;
      if (pop_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_nxt;
    end
  end

  assign head_o     = empty ? '0 : mem[rd_ptr_q];
  assign head_ovr_o = !empty && ovr_q[rd_ptr_q];
  assign cnt_nxt_o  = cnt_nxt;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DEPTH_C); // R5

  AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !pop_i |=> cnt_q >= $past(cnt_q)); // R3

  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && cnt_q >= cap) |=> cnt_q == $past(cnt_q)); // R6

endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          fifo_mode_i,
  input  logic [CW-1:0] trig_level_i,
  input  logic          irq_en_i,
  input  logic          status_rd_i,
  output logic          ready_o,
  output logic          trig_o,
  output logic          irq_o
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] trig_eff;
  logic          at_trig, level_hit, mute_q, mute_nxt;

  always_comb begin
    if (trig_level_i == '0)         trig_eff = CW'(1);
    else if (trig_level_i > DEPTH_C) trig_eff = DEPTH_C;
    else                             trig_eff = trig_level_i;
  end

  assign at_trig   = (cnt_nxt_i >= trig_eff);
  assign level_hit = fifo_mode_i ? at_trig : (cnt_nxt_i != '0);
  // A status read silences the request until the condition goes away.
  assign mute_nxt  = level_hit && (mute_q || status_rd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b0;
      trig_o  <= 1'b0;
      irq_o   <= 1'b0;
      mute_q  <= 1'b0;
    end else begin
      ready_o <= (cnt_nxt_i != '0);
      trig_o  <= fifo_mode_i && at_trig;
      irq_o   <= irq_en_i && level_hit && !mute_nxt;
      mute_q  <= mute_nxt;
    end
  end

  AST_STATUS_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (irq_o && status_rd_i) |=> !irq_o); // R9

  AST_SINGLE_NO_TRIG: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode_i |=> !trig_o); // R11

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [RXQ_CHAR_W-1:0] wr_char,
  input  logic                  wr_frame_err,
  input  logic                  wr_parity_err,
  input  logic                  wr_overrun_err,
  input  logic                  rd_data,
  input  logic                  rd_status,
  input  logic                  fifo_mode,
  input  logic                  irq_enable,
  input  logic [CW-1:0]         trig_level,
  output logic [RXQ_CHAR_W-1:0] hold_char,
  output logic                  head_frame_err,
  output logic                  head_parity_err,
  output logic                  head_overrun_err,
  output logic                  data_ready,
  output logic                  trig_flag,
  output logic                  rx_irq
);

  rxq_word_t     in_word, head_word;
  logic          head_ovr;
  logic [CW-1:0] cnt_nxt;

  assign in_word = '{frame: wr_frame_err, parity: wr_parity_err, ch: wr_char};

  rxq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk        (clk),
    .rst        (rst),
    .push_i     (wr_en),
    .word_i     (in_word),
    .ovr_i      (wr_overrun_err),
    .pop_i      (rd_data),
    .single_i   (!fifo_mode),
    .head_o     (head_word),
    .head_ovr_o (head_ovr),
    .cnt_nxt_o  (cnt_nxt)
  );

  rxq_trigger #(.DEPTH(DEPTH), .CW(CW)) u_trigger (
    .clk          (clk),
    .rst          (rst),
    .cnt_nxt_i    (cnt_nxt),
    .fifo_mode_i  (fifo_mode),
    .trig_level_i (trig_level),
    .irq_en_i     (irq_enable),
    .status_rd_i  (rd_status),
    .ready_o      (data_ready),
    .trig_o       (trig_flag),
    .irq_o        (rx_irq)
  );

  assign hold_char        = head_word.ch;
  assign head_frame_err   = head_word.frame;
  assign head_parity_err  = head_word.parity;
  assign head_overrun_err = head_ovr;

  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> data_ready); // R8

  AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> data_ready); // R4

  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    trig_flag |-> data_ready); // R7

endmodule

// File: tb/test_rx_tagged_fifo.sv
`timescale 1ns/1ps
module test_rx_tagged_fifo;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, wr_frame_err = 0, wr_parity_err = 0, wr_overrun_err = 0;
  logic [7:0] wr_char = 0;
  logic       rd_data = 0, rd_status = 0, fifo_mode = 1, irq_enable = 1;
  logic [4:0] trig_level = 5'd4;
  logic [7:0] hold_char;
  logic       head_frame_err, head_parity_err, head_overrun_err;
  logic       data_ready, trig_flag, rx_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rx_tagged_fifo i_rx_tagged_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
    .wr_frame_err(wr_frame_err), .wr_parity_err(wr_parity_err),
    .wr_overrun_err(wr_overrun_err), .rd_data(rd_data), .rd_status(rd_status),
    .fifo_mode(fifo_mode), .irq_enable(irq_enable), .trig_level(trig_level),
    .hold_char(hold_char), .head_frame_err(head_frame_err),
    .head_parity_err(head_parity_err), .head_overrun_err(head_overrun_err),
    .data_ready(data_ready), .trig_flag(trig_flag), .rx_irq(rx_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One cycle of stimulus, driven and sampled at falling edges.
  task automatic step(input logic w, input logic [7:0] c, input logic f, input logic p,
                      input logic o, input logic rdd, input logic rds);
    wr_en = w; wr_char = c; wr_frame_err = f; wr_parity_err = p; wr_overrun_err = o;
    rd_data = rdd; rd_status = rds;
    @(negedge clk);
    wr_en = 0; rd_data = 0; rd_status = 0;
    wr_frame_err = 0; wr_parity_err = 0; wr_overrun_err = 0;
  endtask

  task automatic push(input logic [7:0] c, input logic f, input logic p, input logic o);
    step(1'b1, c, f, p, o, 1'b0, 1'b0);
  endtask

  task automatic pop();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic status_read();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 ready", data_ready, 0);
    check("R1 trig", trig_flag, 0);
    check("R1 irq", rx_irq, 0);
    check("R1 char", hold_char, 0);
    check("R1 errs", {head_frame_err, head_parity_err, head_overrun_err}, 0);
  endtask

  task automatic t_order_errors();
    trig_level = 5'd16;
    push(8'hA1, 1, 0, 0);
    check("R4 ready after write", data_ready, 1);
    push(8'hB2, 0, 1, 0);
    push(8'hC3, 0, 0, 1);
    check("R2 head char", hold_char, 8'hA1);
    check("R2 head flags", {head_frame_err, head_parity_err, head_overrun_err}, 3'b100);
    status_read();
    check("R3 status read keeps head", hold_char, 8'hA1);
    pop();
    check("R2 second char", hold_char, 8'hB2);
    check("R2 second flags", {head_frame_err, head_parity_err, head_overrun_err}, 3'b010);
    pop();
    check("R2 third char", hold_char, 8'hC3);
    check("R2 third flags", {head_frame_err, head_parity_err, head_overrun_err}, 3'b001);
    pop();
    check("R4 ready clears when empty", data_ready, 0);
    pop();
    check("R4 read on empty ignored", data_ready, 0);
    push(8'h44, 0, 0, 0);
    check("R4 empty read did not shift head", hold_char, 8'h44);
    pop();
  endtask

  task automatic t_full_wrap();
    trig_level = 5'd16;
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 0, 0, 0);
    push(8'hEE, 0, 0, 0);
    check("R6 head unchanged after overflow", hold_char, 8'h10);
    check("R6 head ovr clear", head_overrun_err, 0);
    for (int i = 0; i < 15; i++) begin
      check("R5 order across wrap", hold_char, 8'h10 + 8'(i));
      pop();
    end
    check("R6 newest kept", hold_char, 8'h1F);
    check("R6 newest overrun set", head_overrun_err, 1);
    pop();
    check("R6 extra char discarded", data_ready, 0);
  endtask

  task automatic t_trigger();
    trig_level = 5'd4;
    push(8'h01, 0, 0, 0); push(8'h02, 0, 0, 0); push(8'h03, 0, 0, 0);
    check("R7 below trigger", trig_flag, 0);
    check("R8 no irq below trigger", rx_irq, 0);
    push(8'h04, 0, 0, 0);
    check("R7 trig at level", trig_flag, 1);
    check("R8 irq at level", rx_irq, 1);
    status_read();
    check("R9 status read clears irq", rx_irq, 0);
    check("R7 status read keeps trig", trig_flag, 1);
    push(8'h05, 0, 0, 0);
    check("R9 stays silent above trigger", rx_irq, 0);
    pop();
    check("R9 stays silent at trigger", rx_irq, 0);
    pop();
    check("R10 trig drops below level", trig_flag, 0);
    push(8'h06, 0, 0, 0);
    check("R9 rearmed after dip", rx_irq, 1);
    pop();
    check("R10 irq drops below level", rx_irq, 0);
    check("R10 trig drops", trig_flag, 0);
    pop(); pop(); pop();
    check("R4 drained", data_ready, 0);
  endtask

  task automatic t_clamp();
    trig_level = 5'd0;
    push(8'h21, 0, 0, 0);
    check("R7 zero acts as one", trig_flag, 1);
    check("R8 irq with level one", rx_irq, 1);
    pop();
    trig_level = 5'd31;
    for (int i = 0; i < 15; i++) push(8'h30 + 8'(i), 0, 0, 0);
    check("R7 clamp not yet", trig_flag, 0);
    push(8'h3F, 0, 0, 0);
    check("R7 clamp to sixteen", trig_flag, 1);
    check("R8 irq at clamped level", rx_irq, 1);
    for (int i = 0; i < 16; i++) pop();
    check("R4 drained after clamp", data_ready, 0);
  endtask

  task automatic t_enable();
    trig_level = 5'd2;
    irq_enable = 0;
    push(8'h51, 0, 0, 0); push(8'h52, 0, 0, 0);
    check("R12 disabled irq low", rx_irq, 0);
    check("R12 trig still set", trig_flag, 1);
    irq_enable = 1;
    idle();
    check("R12 enable raises pending irq", rx_irq, 1);
    pop(); pop();
    check("R12 irq low after drain", rx_irq, 0);
  endtask

  task automatic t_single();
    fifo_mode = 0;
    trig_level = 5'd4;
    idle();
    push(8'h5A, 1, 0, 0);
    check("R11 ready", data_ready, 1);
    check("R11 irq follows ready", rx_irq, 1);
    check("R11 no trig flag", trig_flag, 0);
    push(8'hA5, 0, 0, 0);
    check("R11 held char kept", hold_char, 8'h5A);
    check("R11 overrun on held", {head_frame_err, head_overrun_err}, 2'b11);
    status_read();
    check("R11 status read silences", rx_irq, 0);
    pop();
    check("R11 empty after one read", data_ready, 0);
    push(8'h77, 0, 0, 0);
    check("R11 irq rearmed", rx_irq, 1);
    pop();
    fifo_mode = 1;
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order_errors();
    t_full_wrap();
    t_trigger();
    t_clamp();
    t_enable();
    t_single();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule